// File: doc/BRIEF.md
# I2C Slave Register Bank

This block is a slave-only I2C endpoint with a fixed 7-bit device address, 1100100. It gives a bus master access to five 8-bit registers selected by a sub-address byte. A write transaction carries the device address with R/W low, then a sub-address, then one or more data bytes. A read transaction sets the sub-address in the same way, then issues a repeated START and the device address with R/W high. The slave then returns bytes for as long as the master acknowledges them.

SCL is only ever sampled. SDA is received as an input and driven back as an active-low enable for an external open-drain pad. Both lines pass through a two-flop synchronizer into the system clock before any edge is decoded. The registers do not share one access rule:
- Three registers are write-only and drive their values out to the rest of the chip.
- One register is read/write. Its owner sees a one-cycle strobe whenever it is written.
- One register is read-only and reflects a live input bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits are 1100100 (0xC8 for write, 0xC9 for read). For any other address byte it leaves SDA released and stays silent until the next START.
- R2: After a matching write address, the slave acknowledges the sub-address byte and every data byte written (ACK = SDA low on the ninth clock).
- R3: Sub-addresses 0x01, 0x02, 0x03, 0x05 select registers A, B, C, E, whose values appear on `reg_a_o`, `reg_b_o`, `reg_c_o`, `reg_e_o`. Every data byte in one write transaction goes to the same register, with no auto-increment, so the last byte wins.
- R4: After reset A = 0x00, B = 0xFF, C = 0x00 and E = 0x00, and SDA is released.
- R5: A read of sub-address 0x03 returns the stored C value. A read of 0x04 (register D) returns `alarm_i`, sampled when the byte is loaded. A read of 0x01, 0x02, 0x05 or of any unmapped sub-address (0x00, 0x06 to 0xFF) returns 0x00.
- R6: A write to sub-address 0x04 or to an unmapped sub-address changes no register output.
- R7: `c_wr_stb` pulses high for exactly one cycle for each data byte written to register C, and `reg_c_o` changes only in that cycle.
- R8: In a read, the slave sends another byte of the same register after each master ACK. After a master NACK it releases SDA and drives nothing until the next START or STOP.
- R9: `sda_oe` changes only while SCL is low. A START seen in the middle of a byte aborts that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line, sampled only |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| alarm_i | input | 8 | Live value returned when register D is read |
| reg_a_o | output | 8 | Register A contents |
| reg_b_o | output | 8 | Register B contents |
| reg_c_o | output | 8 | Register C contents |
| reg_e_o | output | 8 | Register E contents |
| c_wr_stb | output | 1 | One-cycle pulse on each write to register C |

## Verification
The bench reads back each write-only register. A design that leaked stored contents on reads would return the written byte instead of 0x00. It also writes register D and an unmapped sub-address and checks that all register outputs keep their values. A decoder that aliased those addresses onto a real register would corrupt it.

A foreign address byte must go unacknowledged, or the slave would collide with another device on the bus. A START inserted halfway through a byte must restart reception; otherwise the bit counter stays out of step and every later byte shifts. Multi-byte writes and reads expose a pointer that auto-increments, and they give the strobe count for register C. The bench also clocks one extra byte after a NACK and checks that SDA stays high, which catches a transmitter that keeps driving.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_SUB,
    K_DATA
  } kind_t;

  localparam int IDX_W = 3;

  // True when the received address byte targets this device.
  function automatic logic addr_hit(input logic [7:0] rx_byte, input logic [6:0] dev);
    return rx_byte[7:1] == dev;
  endfunction

  // Maps a sub-address to a register index 1..5; 0 means unmapped.
  function automatic logic [IDX_W-1:0] reg_index(input logic [7:0] sub);
    if (sub >= 8'h01 && sub <= 8'h05) return sub[IDX_W-1:0];
    return '0;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[0] <= 1'b1;
            sda_ff[0] <= 1'b1;
          end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[g] <= 1'b1;
            sda_ff[g] <= 1'b1;
          end else begin
            scl_ff[g] <= scl_ff[g-1];
            sda_ff[g] <= sda_ff[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h64,
  parameter int         DW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [DW-1:0]     rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DW-1:0]     wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  output phase_t            phase,
  output logic              addr_miss
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  kind_t            kind;
  logic [CW-1:0]    cnt;
  logic [DW-1:0]    rx_sh;
  logic [DW-1:0]    tx_sh;
  logic [IDX_W-1:0] ptr;
  logic             rw;
  logic             nack;
  logic             byte_end;

  assign byte_end  = (phase == PH_RX) && scl_fall && (cnt == FULL);
  assign addr_miss = byte_end && (kind == K_ADDR) && !addr_hit(rx_sh, DEV_ADDR);
  assign wr_idx    = ptr;
  assign rd_idx    = ptr;
  assign wr_data   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      kind   <= K_ADDR;
      cnt    <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        phase  <= PH_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise && cnt != FULL) begin
              rx_sh <= {rx_sh[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (addr_hit(rx_sh, DEV_ADDR)) begin
                    rw     <= rx_sh[0];
                    sda_oe <= 1'b1;
                    phase  <= PH_ACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                K_SUB: begin
                  ptr    <= reg_index(rx_sh);
                  sda_oe <= 1'b1;
                  phase  <= PH_ACK;
                end
                default: begin
                  wr_en  <= 1'b1;
                  sda_oe <= 1'b1;
                  phase  <= PH_ACK;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_ADDR && rw) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                kind   <= (kind == K_ADDR) ? K_SUB : K_DATA;
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_rise && cnt != FULL) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                phase  <= PH_TXACK;
              end else begin
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                sda_oe <= ~tx_sh[DW-2];
              end
            end
          end
          PH_TXACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (!nack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
                phase  <= PH_TX;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
  import i2c_regbank_pkg::*;
#(
  parameter int          DW    = 8,
  parameter logic [DW-1:0] DEF_A = '0,
  parameter logic [DW-1:0] DEF_B = '1,
  parameter logic [DW-1:0] DEF_C = '0,
  parameter logic [DW-1:0] DEF_E = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DW-1:0]     alarm_i,
  output logic [DW-1:0]     reg_a,
  output logic [DW-1:0]     reg_b,
  output logic [DW-1:0]     reg_c,
  output logic [DW-1:0]     reg_e,
  output logic [DW-1:0]     rd_data,
  output logic              c_wr_stb
);

  localparam logic [IDX_W-1:0] IX_A = 3'd1;
  localparam logic [IDX_W-1:0] IX_B = 3'd2;
  localparam logic [IDX_W-1:0] IX_C = 3'd3;
  localparam logic [IDX_W-1:0] IX_D = 3'd4;
  localparam logic [IDX_W-1:0] IX_E = 3'd5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a    <= DEF_A;
      reg_b    <= DEF_B;
      reg_c    <= DEF_C;
      reg_e    <= DEF_E;
      c_wr_stb <= 1'b0;
    end else begin
      c_wr_stb <= wr_en && (wr_idx == IX_C);
      if (wr_en) begin
        case (wr_idx)
          IX_A: reg_a <= wr_data;
          IX_B: reg_b <= wr_data;
          IX_C: reg_c <= wr_data;
          IX_E: reg_e <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_idx)
      IX_C:    rd_data = reg_c;
      IX_D:    rd_data = alarm_i;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h64,
  parameter int         DW       = 8,
  parameter int         SYNC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [DW-1:0] alarm_i,
  output logic [DW-1:0] reg_a_o,
  output logic [DW-1:0] reg_b_o,
  output logic [DW-1:0] reg_c_o,
  output logic [DW-1:0] reg_e_o,
  output logic          c_wr_stb
);

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_ev;
  logic             stop_ev;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [DW-1:0]    wr_data;
  logic [DW-1:0]    rd_data;
  logic             addr_miss;
  phase_t           phase;

  i2c_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .phase(phase), .addr_miss(addr_miss)
  );

  i2c_reg_file #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .alarm_i(alarm_i),
    .reg_a(reg_a_o), .reg_b(reg_b_o), .reg_c(reg_c_o), .reg_e(reg_e_o),
    .rd_data(rd_data), .c_wr_stb(c_wr_stb)
  );

endmodule

// File: rtl/i2c_regbank_checker.sv
module i2c_regbank_checker
  import i2c_regbank_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input phase_t           phase,
  input logic             addr_miss,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    reg_a_o,
  input logic [DW-1:0]    reg_b_o,
  input logic [DW-1:0]    reg_c_o,
  input logic [DW-1:0]    reg_e_o,
  input logic             c_wr_stb
);

  AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R9

  AST_MISS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> (!sda_oe && phase == PH_IDLE)); // R1

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe); // R8

  AST_C_CHANGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_c_o != $past(reg_c_o)) |-> c_wr_stb); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_stb |=> !c_wr_stb); // R7

  AST_D_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == 3'd4 || wr_idx == 3'd0)) |=>
      ($stable(reg_a_o) && $stable(reg_b_o) && $stable(reg_c_o) && $stable(reg_e_o))); // R6

endmodule

bind i2c_regbank_slave i2c_regbank_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .phase(phase),
  .addr_miss(addr_miss), .wr_en(wr_en), .wr_idx(wr_idx),
  .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .reg_c_o(reg_c_o), .reg_e_o(reg_e_o),
  .c_wr_stb(c_wr_stb)
);

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NV = 12;

  // {is_read, sub_address, data_or_expected}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h5A},
    {1'b1, 8'h01, 8'h00},
    {1'b0, 8'h02, 8'h3C},
    {1'b0, 8'h03, 8'hA5},
    {1'b1, 8'h03, 8'hA5},
    {1'b0, 8'h04, 8'h11},
    {1'b1, 8'h04, 8'h96},
    {1'b0, 8'h05, 8'h77},
    {1'b1, 8'h05, 8'h00},
    {1'b1, 8'h00, 8'h00},
    {1'b0, 8'h06, 8'hEE},
    {1'b1, 8'h02, 8'h00}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic m_scl = 1;
  logic m_sda = 1;
  logic sda_line;
  logic sda_oe;
  logic c_wr_stb;
  logic [7:0] alarm = 8'h00;
  logic [7:0] reg_a_o, reg_b_o, reg_c_o, reg_e_o;
  logic [7:0] mdl [6];
  int n_chk = 0;
  int n_err = 0;
  int stb_cnt = 0;
  int oe_viol = 0;
  logic oe_prev = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .alarm_i(alarm), .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .reg_c_o(reg_c_o),
    .reg_e_o(reg_e_o), .c_wr_stb(c_wr_stb)
  );

  always @(posedge clk) begin
    if (c_wr_stb) stb_cnt <= stb_cnt + 1;
    if (sda_oe != oe_prev && m_scl) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q);
    end
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); ack = ~sda_line; tick(Q); m_scl = 0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1; tick(Q); b[i] = sda_line; tick(Q); m_scl = 0;
    end
    tick(Q); m_sda = ~give_ack; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q); m_sda = 1;
  endtask

  task automatic do_write(input logic [7:0] sub, input logic [7:0] d);
    logic a0, a1, a2;
    i2c_start(); send_byte(8'hC8, a0); send_byte(sub, a1); send_byte(d, a2); i2c_stop();
    chk("R1 address ack", {7'd0, a0}, 8'd1);
    chk("R2 sub/data ack", {6'd0, a1, a2}, 8'd3);
  endtask

  task automatic do_read(input logic [7:0] sub, output logic [7:0] got);
    logic a0, a1, a2;
    i2c_start(); send_byte(8'hC8, a0); send_byte(sub, a1);
    i2c_start(); send_byte(8'hC9, a2); recv_byte(1'b0, got); i2c_stop();
    chk("R1 read address ack", {5'd0, a0, a1, a2}, 8'd7);
  endtask

  task automatic cmp_ports(input string req);
    chk({req, " A"}, reg_a_o, mdl[1]);
    chk({req, " B"}, reg_b_o, mdl[2]);
    chk({req, " C"}, reg_c_o, mdl[3]);
    chk({req, " E"}, reg_e_o, mdl[5]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, got2;
    logic ack;
    mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'hFF; mdl[3] = 8'h00; mdl[4] = 8'h00; mdl[5] = 8'h00;
    tick(5); rst_n = 1; tick(5);

    // R4: reset defaults
    cmp_ports("R4 reset");
    chk("R4 sda released", {7'd0, sda_oe}, 8'd0);
    do_read(8'h03, got); chk("R4 C default read", got, 8'h00);

    alarm = 8'h96;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][16]) begin
        do_read(VEC[v][15:8], got);
        chk("R5 read value", got, VEC[v][7:0]);
      end else begin
        do_write(VEC[v][15:8], VEC[v][7:0]);
        if (VEC[v][15:8] inside {8'h01, 8'h02, 8'h03, 8'h05})
          mdl[VEC[v][10:8]] = VEC[v][7:0];
        cmp_ports("R3 R6 ports after write");
      end
    end

    // R1: foreign address gets no ACK, nothing changes
    i2c_start(); send_byte(8'hCA, ack); chk("R1 foreign address nack", {7'd0, ack}, 8'd0);
    send_byte(8'h01, ack); chk("R1 silent after miss", {7'd0, ack}, 8'd0);
    send_byte(8'h00, ack); i2c_stop();
    cmp_ports("R1 no write on miss");

    // R3/R7: two data bytes to C, no auto-increment
    i2c_start(); send_byte(8'hC8, ack); send_byte(8'h03, ack);
    send_byte(8'h12, ack); send_byte(8'h34, ack); i2c_stop();
    mdl[3] = 8'h34;
    cmp_ports("R3 multi-byte write");
    chk("R7 strobe count", stb_cnt[7:0], 8'd3);

    // R8: burst read with ACK then NACK, then silence
    i2c_start(); send_byte(8'hC8, ack); send_byte(8'h03, ack);
    i2c_start(); send_byte(8'hC9, ack);
    recv_byte(1'b1, got); recv_byte(1'b0, got2);
    chk("R8 burst byte 1", got, 8'h34);
    chk("R8 burst byte 2", got2, 8'h34);
    recv_byte(1'b0, got); chk("R8 released after nack", got, 8'hFF);
    i2c_stop();

    // R9: START in the middle of a byte restarts reception
    i2c_start();
    for (int i = 7; i >= 4; i--) begin
      m_sda = 1'b1; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q);
    end
    do_write(8'h01, 8'hC3); mdl[1] = 8'hC3;
    cmp_ports("R9 restart mid-byte");
    chk("R9 sda_oe changed only with SCL low", oe_viol[7:0], 8'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule